// File: doc/BRIEF.md
# Alignment and Overflow Exception Stage

This stage sits beside the execute step of a small 32-bit integer core. For every instruction it receives, it works out the data address of a word load (base register plus sign-extended 16-bit offset) and tests that sum for 4-byte alignment. For the signed add forms it also checks whether the adder result has left the 32-bit two's complement range. If either test fails, the stage raises an exception in the same cycle and cancels the instruction's register write, so the faulting instruction leaves no result behind.

At the next rising edge the stage records three things. The first is the address of the faulting instruction. The second is a cause code, held together with a valid flag. The third, for address errors only, is the offending data address. The cause and its valid flag stay put until a software clear arrives. The instruction side is a valid/ready port. `in_ready` is always high, so the stage never stalls its producer: any edge with `in_valid` high consumes one instruction, and cycles with `in_valid` low have no effect.

Top module: `excu_top`

## Requirements
- R1: `eff_addr` always equals `in_base` plus `in_imm` sign-extended to 32 bits, modulo 2^32. A negative offset moves the address down.
- R2: If `in_op` = 1 (word load) and bits [1:0] of the effective address are not both zero, the stage raises an address error with cause code 4. Only the effective address is tested, so a misaligned base with an aligned sum raises nothing.
- R3: If `in_op` = 2 (signed add) or 3 (signed add-immediate), the stage raises an overflow with cause code 12 when the true signed sum of `in_opa` and `in_opb` lies outside -2^31..2^31-1. For example, 0x7FFFFFFF + 1 overflows.
- R4: Opcodes 4 (unsigned add), 5 (unsigned add-immediate), 0 (any other instruction) and 6 to 7 never raise an exception, whatever their operands.
- R5: On the edge after an exception is raised, `epc_q` holds the `in_pc` of the faulting instruction.
- R6: On an address error, `badva_q` takes the misaligned effective address (base 2022 with offset 21 gives 2043). An overflow exception leaves `badva_q` unchanged.
- R7: `wb_en` equals `in_valid & in_wr_req` when no exception is raised and is 0 when one is raised, in the same cycle.
- R8: `exc_raise` is high combinationally for a faulting instruction. On the following edge `exc_valid_q` becomes 1 and `cause_q` takes the code. Both hold until `clr_exc` is high on an edge with no new exception, which returns them to 0 and 0. A new exception on the same edge as the clear takes precedence.
- R9: A synchronous active-high `rst` clears `exc_valid_q`, `cause_q`, `epc_q` and `badva_q` to zero.
- R10: `in_ready` is always 1. With `in_valid` low the stage raises nothing, asserts no write-back and leaves every capture register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_ready | output | 1 | Always 1; the stage never stalls |
| in_pc | input | 32 | Instruction address |
| in_op | input | 3 | Operation class: 0 other, 1 word load, 2 signed add, 3 signed add-imm, 4 unsigned add, 5 unsigned add-imm |
| in_base | input | 32 | Base register value for the load address |
| in_imm | input | 16 | Signed address offset |
| in_opa | input | 32 | First adder operand |
| in_opb | input | 32 | Second adder operand |
| in_sum | input | 32 | Adder result, opa + opb modulo 2^32 |
| in_wr_req | input | 1 | Instruction wants to write its destination register |
| clr_exc | input | 1 | Software clear of the cause and valid flag |
| eff_addr | output | 32 | Computed effective address |
| exc_raise | output | 1 | Exception detected this cycle |
| wb_en | output | 1 | Register write permitted this cycle |
| exc_valid_q | output | 1 | A captured exception is pending |
| cause_q | output | 5 | Captured cause code (0, 4 or 12) |
| epc_q | output | 32 | Captured faulting instruction address |
| badva_q | output | 32 | Captured faulting data address |

## Verification
The overflow properties assume that `in_sum` really is `in_opa + in_opb` modulo 2^32. The stage does not compute the sum itself, so a wrong sum would be judged as given. The bench therefore always forms `in_sum` from the operands it drives, drawing the operands either at random or from the extreme values near 0x7FFFFFFF and 0x80000000. The bench draws `in_op` from all eight codes, so the unused values 6 and 7 are exercised as non-trapping. It changes inputs only one time unit after a rising edge, so the combinational outputs are settled before the next edge samples them.

// File: rtl/excu_pkg.sv
package excu_pkg;

  typedef enum logic [2:0] {
    OP_OTHER = 3'd0,
    OP_LDW   = 3'd1,
    OP_ADDS  = 3'd2,
    OP_ADDIS = 3'd3,
    OP_ADDU  = 3'd4,
    OP_ADDIU = 3'd5
  } op_e;

  localparam int CAUSE_W = 5;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE  = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ALIGN = 5'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_OVF   = 5'd12;

endpackage

// File: rtl/excu_ea_calc.sv
module excu_ea_calc #(
  parameter int XLEN        = 32,
  parameter int IMM_W       = 16,
  parameter int ALIGN_BYTES = 4
) (
  input  logic [XLEN-1:0]  base,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  ea,
  output logic             misaligned
);
  localparam int LSB = (ALIGN_BYTES > 1) ? $clog2(ALIGN_BYTES) : 1;

  logic [XLEN-1:0] imm_ext;

  always_comb begin
    imm_ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    ea      = base + imm_ext;
  end

  generate
    if (ALIGN_BYTES > 1) begin : g_chk
      assign misaligned = |ea[LSB-1:0];
    end else begin : g_nochk
      assign misaligned = 1'b0;
    end
  endgenerate

  // R1: the low offset bits pass straight into the sum (no carry below bit 0)
  always_comb begin
    assert_ea_low_bit_R1: assert (ea[0] == (base[0] ^ imm[0]));
  end

endmodule

// File: rtl/excu_ovf_det.sv
module excu_ovf_det #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [XLEN-1:0] sum,
  output logic            ovf
);
  logic sa, sb, ss;

  always_comb begin
    sa  = opa[XLEN-1];
    sb  = opb[XLEN-1];
    ss  = sum[XLEN-1];
    ovf = (sa == sb) && (ss != sa);
  end

  // R3: operands of opposite sign can never overflow
  always_comb begin
    assert_mixed_sign_safe_R3: assert (!((sa != sb) && ovf));
  end

endmodule

// File: rtl/excu_capture.sv
module excu_capture
  import excu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               raise,
  input  logic [CAUSE_W-1:0] code,
  input  logic [XLEN-1:0]    pc,
  input  logic [XLEN-1:0]    badva_in,
  input  logic               badva_we,
  input  logic               clr,
  output logic               valid_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [XLEN-1:0]    epc_q,
  output logic [XLEN-1:0]    badva_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      cause_q <= CAUSE_NONE;
      epc_q   <= '0;
      badva_q <= '0;
    end else if (raise) begin
      valid_q <= 1'b1;
      cause_q <= code;
      epc_q   <= pc;
      if (badva_we) badva_q <= badva_in;
    end else if (clr) begin
      valid_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end
  end

  // R5: faulting instruction address captured
  assert_epc_capture_R5: assert property (@(posedge clk) disable iff (rst)
    raise |=> (epc_q == $past(pc)));

  // R6: overflow keeps the old bad address
  assert_badva_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (raise && !badva_we) |=> (badva_q == $past(badva_q)));

  // R8: clear without a new exception empties the flag
  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clr && !raise) |=> (!valid_q && cause_q == CAUSE_NONE));

  // R8: a new exception wins over a clear
  assert_raise_wins_R8: assert property (@(posedge clk) disable iff (rst)
    raise |=> valid_q);

endmodule

// File: rtl/excu_top.sv
module excu_top
  import excu_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int IMM_W       = 16,
  parameter int ALIGN_BYTES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [XLEN-1:0]    in_pc,
  input  logic [2:0]         in_op,
  input  logic [XLEN-1:0]    in_base,
  input  logic [IMM_W-1:0]   in_imm,
  input  logic [XLEN-1:0]    in_opa,
  input  logic [XLEN-1:0]    in_opb,
  input  logic [XLEN-1:0]    in_sum,
  input  logic               in_wr_req,
  input  logic               clr_exc,
  output logic [XLEN-1:0]    eff_addr,
  output logic               exc_raise,
  output logic               wb_en,
  output logic               exc_valid_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [XLEN-1:0]    epc_q,
  output logic [XLEN-1:0]    badva_q
);

  logic               misal;
  logic               ovf;
  logic               is_load;
  logic               is_sadd;
  logic               is_uadd;
  logic               align_err;
  logic               ovf_err;
  logic [CAUSE_W-1:0] code;

  excu_ea_calc #(
    .XLEN(XLEN), .IMM_W(IMM_W), .ALIGN_BYTES(ALIGN_BYTES)
  ) i_ea (
    .base(in_base), .imm(in_imm), .ea(eff_addr), .misaligned(misal)
  );

  excu_ovf_det #(.XLEN(XLEN)) i_ovf (
    .opa(in_opa), .opb(in_opb), .sum(in_sum), .ovf(ovf)
  );

  always_comb begin
    in_ready  = 1'b1;
    is_load   = in_valid && (in_op == OP_LDW);
    is_sadd   = in_valid && ((in_op == OP_ADDS) || (in_op == OP_ADDIS));
    is_uadd   = (in_op == OP_ADDU) || (in_op == OP_ADDIU);
    align_err = is_load && misal;
    ovf_err   = is_sadd && ovf && !align_err;
    exc_raise = align_err || ovf_err;
    if (align_err)    code = CAUSE_ALIGN;
    else if (ovf_err) code = CAUSE_OVF;
    else              code = CAUSE_NONE;
    wb_en     = in_valid && in_wr_req && !exc_raise;
  end

  excu_capture #(.XLEN(XLEN)) i_cap (
    .clk(clk), .rst(rst),
    .raise(exc_raise), .code(code), .pc(in_pc),
    .badva_in(eff_addr), .badva_we(align_err), .clr(clr_exc),
    .valid_q(exc_valid_q), .cause_q(cause_q),
    .epc_q(epc_q), .badva_q(badva_q)
  );

  // R2: misaligned word load is recorded as an address error
  assert_misaligned_load_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_LDW && eff_addr[1:0] != 2'b00)
      |=> (exc_valid_q && cause_q == CAUSE_ALIGN));

  // R3: signed add with same-sign inputs and flipped result sign traps
  assert_signed_ovf_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_op == OP_ADDS || in_op == OP_ADDIS) &&
     in_opa[XLEN-1] == in_opb[XLEN-1] && in_sum[XLEN-1] != in_opa[XLEN-1])
      |=> (exc_valid_q && cause_q == CAUSE_OVF));

  // R4: unsigned forms never trap
  assert_no_unsigned_trap_R4: assert property (@(posedge clk) disable iff (rst)
    is_uadd |-> !exc_raise);

  // R7: write-back is cancelled for a faulting instruction
  assert_wb_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    exc_raise |-> !wb_en);

  // R10: idle cycles leave the capture state untouched
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !clr_exc) |=> ($stable(exc_valid_q) && $stable(cause_q) &&
                                  $stable(epc_q) && $stable(badva_q)));

endmodule

// File: tb/test_excu_top.sv
module test_excu_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pc = '0;
  logic [2:0]  in_op = '0;
  logic [31:0] in_base = '0;
  logic [15:0] in_imm = '0;
  logic [31:0] in_opa = '0;
  logic [31:0] in_opb = '0;
  logic [31:0] in_sum = '0;
  logic        in_wr_req = 1'b0;
  logic        clr_exc = 1'b0;
  logic [31:0] eff_addr;
  logic        exc_raise;
  logic        wb_en;
  logic        exc_valid_q;
  logic [4:0]  cause_q;
  logic [31:0] epc_q;
  logic [31:0] badva_q;

  int nchk = 0;
  int nfail = 0;

  logic        m_valid;
  logic [4:0]  m_cause;
  logic [31:0] m_epc;
  logic [31:0] m_badva;

  always #2 clk = ~clk;

  excu_top i_excu_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_op(in_op), .in_base(in_base), .in_imm(in_imm),
    .in_opa(in_opa), .in_opb(in_opb), .in_sum(in_sum), .in_wr_req(in_wr_req),
    .clr_exc(clr_exc), .eff_addr(eff_addr), .exc_raise(exc_raise),
    .wb_en(wb_en), .exc_valid_q(exc_valid_q), .cause_q(cause_q),
    .epc_q(epc_q), .badva_q(badva_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ea(input logic [31:0] b, input logic [15:0] i);
    longint sb = longint'($signed(b));
    longint si = longint'($signed(i));
    return 32'(sb + si);
  endfunction

  function automatic logic exp_ovf(input logic [31:0] a, input logic [31:0] b);
    longint s = longint'($signed(a)) + longint'($signed(b));
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  task automatic check_regs(input string tag);
    chk({tag, " R8 valid"}, {31'd0, exc_valid_q}, {31'd0, m_valid});
    chk({tag, " R8 cause"}, {27'd0, cause_q}, {27'd0, m_cause});
    chk({tag, " R5 epc"}, epc_q, m_epc);
    chk({tag, " R6 badva"}, badva_q, m_badva);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    clr_exc = 1'b0;
    @(posedge clk); #1;
    rst = 1'b0;
    m_valid = 1'b0; m_cause = 5'd0; m_epc = '0; m_badva = '0;
    check_regs("R9 reset");
  endtask

  task automatic step(input logic v, input logic [2:0] op, input logic [31:0] pc,
                      input logic [31:0] base, input logic [15:0] imm,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic wr, input logic clr);
    logic [31:0] ea;
    logic        aerr, oerr, r;
    in_valid = v; in_op = op; in_pc = pc; in_base = base; in_imm = imm;
    in_opa = a; in_opb = b; in_sum = a + b; in_wr_req = wr; clr_exc = clr;
    #1;
    ea   = exp_ea(base, imm);
    aerr = v && (op == 3'd1) && (ea[1:0] != 2'b00);
    oerr = v && (op == 3'd2 || op == 3'd3) && exp_ovf(a, b);
    r    = aerr || oerr;
    chk("R1 eff_addr", eff_addr, ea);
    chk("R2/R3/R4 exc_raise", {31'd0, exc_raise}, {31'd0, r});
    chk("R7 wb_en", {31'd0, wb_en}, {31'd0, v && wr && !r});
    chk("R10 in_ready", {31'd0, in_ready}, 32'd1);
    if (r) begin
      m_valid = 1'b1;
      m_cause = aerr ? 5'd4 : 5'd12;
      m_epc   = pc;
      if (aerr) m_badva = ea;
    end else if (clr) begin
      m_valid = 1'b0;
      m_cause = 5'd0;
    end
    @(posedge clk); #1;
    check_regs("post-edge");
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom % 6)
      0: return 32'h7FFFFFFF - ($urandom % 4);
      1: return 32'h80000000 + ($urandom % 4);
      2: return $urandom % 8;
      3: return 32'hFFFFFFFF - ($urandom % 8);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5EED1234));
    @(posedge clk); #1;
    do_reset();

    // R2 R6 R5: base 2022 + 21 -> 2043 misaligned
    step(1, 3'd1, 32'h0040_0100, 32'd2022, 16'd21, 0, 0, 1, 0);
    chk("R6 badva 2043", badva_q, 32'd2043);
    chk("R2 cause 4", {27'd0, cause_q}, 32'd4);
    // R2: misaligned base, aligned sum -> no error
    step(1, 3'd1, 32'h0040_0104, 32'd2022, 16'd2, 0, 0, 1, 0);
    // R1: negative offset
    step(1, 3'd1, 32'h0040_0108, 32'h100, 16'hFFFC, 0, 0, 1, 0);
    chk("R1 negative offset", eff_addr, 32'hFC);
    // R3: 0x7FFFFFFF + 1 on signed add-immediate
    step(1, 3'd3, 32'h0040_010C, 0, 0, 32'h7FFFFFFF, 32'd1, 1, 0);
    chk("R3 cause 12", {27'd0, cause_q}, 32'd12);
    chk("R6 badva kept on overflow", badva_q, 32'd2043);
    // R4: same operands, unsigned form
    step(1, 3'd5, 32'h0040_0110, 0, 0, 32'h7FFFFFFF, 32'd1, 1, 0);
    // R3: negative overflow on signed add
    step(1, 3'd2, 32'h0040_0114, 0, 0, 32'h80000000, 32'hFFFFFFFF, 1, 0);
    // R10: idle misaligned load does nothing
    step(0, 3'd1, 32'h0040_0118, 32'd3, 16'd0, 0, 0, 1, 0);
    // R8: clear
    step(0, 3'd0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 cleared", {31'd0, exc_valid_q}, 32'd0);
    // R8: exception and clear on same edge
    step(1, 3'd1, 32'h0040_0200, 32'd5, 16'd0, 0, 0, 0, 1);
    chk("R8 raise beats clear", {31'd0, exc_valid_q}, 32'd1);
    // R9: reset in the middle
    do_reset();

    for (int k = 0; k < 600; k++) begin
      logic [2:0]  op = 3'($urandom % 8);
      logic [31:0] base = (($urandom % 2) == 0) ? {$urandom} & 32'hFFFFFFFC : $urandom;
      step(($urandom % 5) != 0, op, {$urandom} & 32'hFFFFFFFC, base,
           16'($urandom), pick_val(), pick_val(), 1'($urandom), ($urandom % 8) == 0);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule